// File: doc/BRIEF.md
# Synchronized Divider and Phase-Frequency Detector

This block is the digital heart of an integer-N frequency synthesizer loop. A programmable main counter divides the fast loop clock. Its ratio is a fixed base value plus a small code word, and the code word comes from an external programming register. A second counter divides a crystal-derived reference by a fixed ratio. A three-state phase-frequency detector compares the terminal pulses of the two counters. It drives a pump-up request while the reference leads and a pump-down request while the divided loop clock leads. Each request lasts exactly as long as the two edges are apart.

The reference side is modelled as a clock-enable in the loop clock domain, so the whole block has one clock. A loop-enable input starts and stops the loop. Starting the loop clears both counters and the detector in the same cycle, so the first comparison begins with no phase offset. Stopping the loop is held off until any pump request in progress has run to its natural end. A new code word is taken only when the main counter wraps.

Top module: `pll_divider_pfd`

## Requirements
- R1: While rst_n is low at a clock edge, pump_up, pump_dn, main_pulse, ref_pulse and loop_active are all low after that edge.
- R2: While the loop runs, main_pulse is high for one cycle every MAIN_BASE + code cycles, where code is the unsigned value of ratio_code taken as described in R9 (1024 to 1151 at the defaults).
- R3: While the loop runs, ref_pulse is high in the cycle of every REF_DIV-th cycle with ref_tick high, counted from the start of the loop.
- R4: When ref_pulse occurs without main_pulse while pump_dn is low and loop_en is high, pump_up is high from the next cycle. It stays high up to and including the cycle of the next main_pulse, so its width in cycles equals the distance between the two edges.
- R5: When main_pulse occurs without ref_pulse while pump_up is low and loop_en is high, pump_dn is high from the next cycle. It stays high up to and including the cycle of the next ref_pulse.
- R6: pump_up and pump_dn are never high in the same cycle. An edge that arrives while the opposite request is pending, or two edges in the same cycle, leave both low in the next cycle.
- R7: A high loop_en in a cycle with loop_active low sets loop_active in the next cycle. Both counters then start from zero, so the first main_pulse falls MAIN_BASE + code - 1 cycles after loop_active rises. With equal periods and aligned ticks, no pump request appears at all.
- R8: When loop_en goes low while a pump request is high, loop_active stays high and the request keeps its full width. No new request starts while loop_en is low. loop_active falls in the cycle after the first cycle with loop_en low and both requests low.
- R9: A new ratio_code value is used only from the wrap of the main counter (or from the start of the loop). The period in progress keeps the old ratio.
- R10: While loop_active is low, pump_up, pump_dn, main_pulse and ref_pulse stay low, whatever ref_tick and ratio_code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock (output of the prescaled loop oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per crystal reference clock period |
| loop_en | input | 1 | High runs the loop, low stops it after any pending request |
| ratio_code | input | CODE_W | Offset added to MAIN_BASE to form the main divide ratio |
| pump_up | output | 1 | Charge-pump source request (reference leads) |
| pump_dn | output | 1 | Charge-pump sink request (divided loop clock leads) |
| main_pulse | output | 1 | Terminal-count pulse of the main counter |
| ref_pulse | output | 1 | Terminal-count pulse of the reference counter |
| loop_active | output | 1 | High while the counters and detector are running |

## Verification
The bench builds the block with CODE_W = 3, MAIN_BASE = 8 and REF_DIV = 4. This gives main periods of 8 to 15 cycles against a reference period of 4, 8 or 12 cycles for tick spacings of one to three. Every code is swept against every tick spacing. The sweep reaches leading, lagging and coincident edges, the zero-offset start at equal periods, and ratio changes in the middle of a period. It also drops the enable during a live pump request, and all of this runs in a few hundred cycles per case.

// File: rtl/pll_divider_pfd_pkg.sv
// Shared types of the divider / phase detector core.
package pll_divider_pfd_pkg;
    // Loop run state: counters held in IDLE, counting in RUN.
    typedef enum logic {
        LOOP_IDLE = 1'b0,
        LOOP_RUN  = 1'b1
    } loop_state_e;
endpackage

// File: rtl/pll_main_div.sv
// Programmable main counter.
// Divides clk by MAIN_BASE + ratio_q and emits a one-cycle terminal pulse.
// Assumes MAIN_BASE >= 2. The code word is latched while stopped and at
// each wrap, so a running period never mixes two ratios.
module pll_main_div #(
    parameter int CODE_W    = 7,
    parameter int MAIN_BASE = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              div_pulse
);
    localparam int MAX_RATIO = MAIN_BASE + (1 << CODE_W) - 1;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    logic [CNT_W-1:0]  count;
    logic [CODE_W-1:0] ratio_q;
    logic [CNT_W-1:0]  terminal;

    // Last count value of the current period.
    always_comb begin
        terminal = CNT_W'(MAIN_BASE - 1) + CNT_W'(ratio_q);
    end

    assign div_pulse = running && (count == terminal);

    // Count while running, wrap and reload the ratio at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            ratio_q <= '0;
        end else if (!running) begin
            count   <= '0;
            ratio_q <= ratio_code;
        end else if (div_pulse) begin
            count   <= '0;
            ratio_q <= ratio_code;
        end else begin
            count   <= count + 1'b1;
        end
    end

    // R9: ratio only changes at a wrap while running
    assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !div_pulse) |=> $stable(ratio_q));

    // R2: the counter never runs past its terminal value
    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count <= terminal));
endmodule

// File: rtl/pll_ref_div.sv
// Fixed reference counter.
// Counts ref_tick enables and pulses on every REF_DIV-th one.
// Assumes REF_DIV >= 2; held at zero while the loop is stopped.
module pll_ref_div #(
    parameter int REF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic tick,
    output logic div_pulse
);
    localparam int RW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;

    logic [RW-1:0] count;

    assign div_pulse = running && tick && (count == RW'(REF_DIV - 1));

    // Advance on each tick, wrap on the last one, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            count <= '0;
        end else if (div_pulse) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // R3: two reference pulses are never adjacent
    assert_ref_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
endmodule

// File: rtl/pll_pfd.sv
// Three-state phase-frequency detector.
// A reference edge raises up, a main edge raises dn; when both are pending,
// both clear. With arm low no new request starts, but a pending one still
// ends on its closing edge. Cleared while the loop is stopped.
module pll_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic arm,
    input  logic ref_edge,
    input  logic main_edge,
    output logic up,
    output logic dn
);
    logic up_set, dn_set, up_nxt, dn_nxt;

    // Next request state from the current one and the incoming edges.
    always_comb begin
        up_set = up || ref_edge;
        dn_set = dn || main_edge;
        if (up_set && dn_set) begin
            up_nxt = 1'b0;
            dn_nxt = 1'b0;
        end else begin
            up_nxt = up_set && (up || arm);
            dn_nxt = dn_set && (dn || arm);
        end
    end

    // Register the requests; clear them while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nxt;
            dn <= dn_nxt;
        end
    end

    // R4: a lone reference edge while armed opens a source request
    assert_up_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && arm && ref_edge && !main_edge && !dn) |=> up);

    // R5: a lone main edge while armed opens a sink request
    assert_dn_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && arm && main_edge && !ref_edge && !up) |=> dn);

    // R6: requests are mutually exclusive
    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    // R6: the closing edge of a source request ends it
    assert_up_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up && main_edge) |=> !up && !dn);
endmodule

// File: rtl/pll_divider_pfd.sv
// Synchronized divider and phase detector top.
// Runs both counters and the detector while enabled, restarts them together
// from zero on enable, and delays stopping until no request is pending.
// Assumes ref_tick is a one-cycle enable already in the clk domain.
module pll_divider_pfd
    import pll_divider_pfd_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int MAIN_BASE = 1024,
    parameter int REF_DIV   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              loop_en,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              main_pulse,
    output logic              ref_pulse,
    output logic              loop_active
);
    loop_state_e state, state_nxt;
    logic        running;

    assign running     = (state == LOOP_RUN);
    assign loop_active = running;

    // Start on enable; stop only once enable is low and no request pends.
    always_comb begin
        state_nxt = state;
        if (state == LOOP_IDLE) begin
            if (loop_en) state_nxt = LOOP_RUN;
        end else if (!loop_en && !pump_up && !pump_dn) begin
            state_nxt = LOOP_IDLE;
        end
    end

    // Run-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LOOP_IDLE;
        else        state <= state_nxt;
    end

    pll_main_div #(
        .CODE_W    (CODE_W),
        .MAIN_BASE (MAIN_BASE)
    ) u_main_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .ratio_code (ratio_code),
        .div_pulse  (main_pulse)
    );

    pll_ref_div #(
        .REF_DIV (REF_DIV)
    ) u_ref_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .tick      (ref_tick),
        .div_pulse (ref_pulse)
    );

    pll_pfd u_pfd (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .arm       (loop_en),
        .ref_edge  (ref_pulse),
        .main_edge (main_pulse),
        .up        (pump_up),
        .dn        (pump_dn)
    );

    // R8: a pending request keeps the loop alive after enable drops
    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && !loop_en && (pump_up || pump_dn)) |=> loop_active);

    // R10: nothing toggles while stopped
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_active |-> !pump_up && !pump_dn && !main_pulse && !ref_pulse);

    // R7: the loop starts with no request pending
    assert_clean_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_active) |-> !pump_up && !pump_dn);
endmodule

// File: tb/pll_divider_pfd_bench.sv
// Sweep bench: every code against tick spacings 1..3 on a small configuration.
module pll_divider_pfd_bench;
    localparam int CW   = 3;
    localparam int BASE = 8;
    localparam int RD   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          loop_en = 1'b0;
    logic [CW-1:0] ratio_code = '0;
    logic pump_up, pump_dn, main_pulse, ref_pulse, loop_active;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // expectation state, advanced each rising edge from the requirements
    bit m_run = 0, m_up = 0, m_dn = 0;
    int m_mc = 0, m_rc = 0, m_rat = 0;

    always #10 clk = ~clk;

    pll_divider_pfd #(
        .CODE_W    (CW),
        .MAIN_BASE (BASE),
        .REF_DIV   (RD)
    ) u_pll_divider_pfd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick    (ref_tick),
        .loop_en     (loop_en),
        .ratio_code  (ratio_code),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .main_pulse  (main_pulse),
        .ref_pulse   (ref_pulse),
        .loop_active (loop_active)
    );

    // expected loop behaviour per clock edge
    always @(posedge clk) begin
        bit me, re, su, sd, nu, nd, nrun;
        if (!rst_n) begin
            m_run = 0; m_up = 0; m_dn = 0; m_mc = 0; m_rc = 0; m_rat = int'(ratio_code);
        end else if (!m_run) begin
            m_rat = int'(ratio_code); m_mc = 0; m_rc = 0; m_up = 0; m_dn = 0;
            m_run = loop_en;
        end else begin
            me = (m_mc == BASE + m_rat - 1);
            re = ref_tick && (m_rc == RD - 1);
            nrun = loop_en || m_up || m_dn;
            su = m_up || re;
            sd = m_dn || me;
            if (su && sd) begin
                nu = 0; nd = 0;
            end else begin
                nu = su && (m_up || loop_en);
                nd = sd && (m_dn || loop_en);
            end
            if (me) begin
                m_mc = 0; m_rat = int'(ratio_code);
            end else begin
                m_mc = m_mc + 1;
            end
            if (ref_tick) m_rc = re ? 0 : m_rc + 1;
            m_up = nu; m_dn = nd; m_run = nrun;
            if (!nrun) begin
                m_mc = 0; m_rc = 0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare all outputs with the expectation for the current cycle
    task automatic compare_all();
        int e_me, e_re;
        e_me = (m_run && m_mc == BASE + m_rat - 1) ? 1 : 0;
        e_re = (m_run && ref_tick && m_rc == RD - 1) ? 1 : 0;
        check("R2", "main_pulse", int'(main_pulse), e_me);
        check("R3", "ref_pulse", int'(ref_pulse), e_re);
        check("R4", "pump_up", int'(pump_up), int'(m_up));
        check("R5", "pump_dn", int'(pump_dn), int'(m_dn));
        check("R8", "loop_active", int'(loop_active), int'(m_run));
        check("R6", "exclusive", int'(pump_up && pump_dn), 0);
    endtask

    // one cycle: drive tick for the cycle, settle, compare
    task automatic step(input bit tick_val);
        @(negedge clk);
        ref_tick = tick_val;
        #1;
        compare_all();
    endtask

    task automatic run_case(input int tp, input int code);
        int up_cnt, dn_cnt, t, win;
        // R1: reset clears everything
        @(negedge clk);
        rst_n = 1'b0; loop_en = 1'b0; ref_tick = 1'b0; ratio_code = CW'(code);
        repeat (2) @(negedge clk);
        #1;
        check("R1", "outputs in reset",
              int'({pump_up, pump_dn, main_pulse, ref_pulse, loop_active}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        ref_tick = 1'b0;
        loop_en = 1'b1;
        up_cnt = 0; dn_cnt = 0;
        win = (tp == 3) ? 13 : 16;
        for (t = 0; t < 110; t++) begin
            if (t == 60) ratio_code = CW'((code + 3) % 8);  // R9 mid-period change
            step(((t + 1) % tp) == 0);
            if (t == 0) check("R7", "active after enable", int'(loop_active), 1);
            if (t < win) begin
                up_cnt += int'(pump_up);
                dn_cnt += int'(pump_dn);
            end
        end
        // R7, R4, R5: first comparison widths from a zero-offset start
        if (tp == 2) begin
            check("R4", "first up width", up_cnt, code);
            check("R7", "first dn width", dn_cnt, 0);
        end
        if (tp == 3) begin
            check("R5", "first dn width", dn_cnt, (code < 4) ? 4 - code : 0);
        end
        // R8: wait for a live request, then drop the enable
        for (int w = 0; w < 30 && !(pump_up || pump_dn); w++) begin
            step(((t + 1) % tp) == 0);
            t++;
        end
        loop_en = 1'b0;
        while (pump_up || pump_dn) begin
            step(((t + 1) % tp) == 0);
            t++;
            check("R8", "active while draining", int'(loop_active), 1);
        end
        step(((t + 1) % tp) == 0);
        t++;
        check("R8", "stopped after drain", int'(loop_active), 0);
        // R10: stopped loop stays quiet under ticks and code changes
        for (int k = 0; k < 20; k++) begin
            ratio_code = CW'(k);
            step(k[0]);
            check("R10", "quiet while stopped",
                  int'({pump_up, pump_dn, main_pulse, ref_pulse, loop_active}), 0);
        end
    endtask

    initial begin
        for (int tp = 1; tp <= 3; tp++) begin
            for (int code = 0; code < 8; code++) begin
                run_case(tp, code);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule